// File: doc/BRIEF.md
# Receive Fabric Width Adapter

This block sits at the boundary between a receiver's fixed four-lane internal data path and the user logic that consumes it. Each internal word carries four byte lanes plus one control (K-character) flag per lane. A two-bit width selector chooses how wide the user-side word is: one, two, four or eight lanes. In the narrow settings each internal word is handed out as a burst of smaller user words, lowest lane first. In the four-lane setting it passes straight through. In the eight-lane setting two consecutive internal words are joined into one wide user word.

Both sides run on a single clock. The internal side is an enable (`int_valid`) that pulses at the internal word rate, and the user side is a strobe (`usr_valid`). In narrow settings the user strobe fires on more cycles than `int_valid`, which models a faster user clock. In the eight-lane setting it fires on fewer cycles, which models a slower one. A change of the selector clears any partly split or partly paired word, so the new setting always starts from a clean lane boundary.

Top module: `rx_fabric_width_adapter`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `usr_valid`, `usr_data` and `usr_ctl` are all zero.
- R2: `width_sel` is decoded as 2'b00 = one lane, 2'b01 = two lanes, 2'b10 = four lanes and 2'b11 = eight lanes per user word.
- R3: In one-lane mode, an internal word accepted on one clock edge appears as four user words on the next four edges. Lane 0 comes first and lane 3 last, each placed in `usr_data[7:0]`.
- R4: In two-lane mode, an accepted internal word appears as two user words on the next two edges. Lanes 1:0 come first, in `usr_data[15:0]`, followed by lanes 3:2.
- R5: In four-lane mode, an accepted internal word appears in `usr_data[31:0]` with `usr_valid` high on the next edge.
- R6: In eight-lane mode, accepting the first word of a pair produces no user word. Accepting the second word produces, on the next edge, one user word with the earlier internal word in bits [31:0] and the later one in bits [63:32]. Two user words therefore never appear on adjacent cycles.
- R7: Control flag `usr_ctl[i]` always belongs to the byte in `usr_data[8*i+7:8*i]` and moves with that byte through splitting and pairing.
- R8: Whenever `usr_valid` is high, every data lane and control flag above the selected width is zero.
- R9: In one-lane and two-lane modes, an internal word that arrives before the previous word has been fully handed out takes over on the next edge. The unsent pieces of the older word are dropped.
- R10: On a cycle where `width_sel` differs from the width currently in use, `int_valid` is ignored and `usr_valid` is low on the next cycle. Any pending pieces of a split word, and any held first half of a pair, are discarded. The new width applies from the following cycle onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both sides |
| rst | input | 1 | Synchronous reset, active high |
| width_sel | input | 2 | User-side width select (R2 encoding) |
| int_valid | input | 1 | Internal word present this cycle |
| int_data | input | 32 | Internal word, four 8-bit lanes, lane 0 in bits [7:0] |
| int_ctl | input | 4 | Per-lane control flags of the internal word |
| usr_valid | output | 1 | User word present this cycle |
| usr_data | output | 64 | User word, eight lanes, unused upper lanes zero |
| usr_ctl | output | 8 | Per-lane control flags of the user word |

## Verification
The hardest states to reach from the ports are those where a width change lands in the middle of unfinished work. One case is a held first half of an eight-lane pair. The other is a one-lane burst with bytes still pending. The stimulus sends a single word in eight-lane mode, then switches to four-lane mode with `int_valid` high on that same cycle, and then switches back. After that it sends a clean pair, and the scoreboard expects only that pair: a stale low half, or the discarded word, would show up as an extra or wrong entry. A second case switches from one-lane to two-lane mode one cycle into a four-byte burst, and expects the remaining three bytes never to appear.

// File: rtl/rfwa_pkg.sv
package rfwa_pkg;

   // User-side width selector encoding
   typedef enum logic [1:0] {
      W_1L = 2'b00,
      W_2L = 2'b01,
      W_4L = 2'b10,
      W_8L = 2'b11
   } rx_width_e;

   localparam int INT_LANES = 4;
   localparam int USR_LANES = 2 * INT_LANES;

endpackage

// File: rtl/rfwa_mode_track.sv
module rfwa_mode_track
   import rfwa_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  logic [1:0] width_sel,
   output rx_width_e width_q,
   output logic      flush
);

   // A differing selector marks a settling cycle for every datapath
   assign flush = (width_sel != width_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         width_q <= rx_width_e'(width_sel);
      end else if (flush) begin
         width_q <= rx_width_e'(width_sel);
      end
   end

endmodule

// File: rtl/rfwa_spread.sv
module rfwa_spread
   import rfwa_pkg::*;
#(
   parameter int LANE_W = 8
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        flush,
   input  logic                        en,
   input  logic                        half,
   input  logic                        in_valid,
   input  logic [INT_LANES*LANE_W-1:0] in_data,
   input  logic [INT_LANES-1:0]        in_ctl,
   output logic                        out_valid,
   output logic [INT_LANES*LANE_W-1:0] out_data,
   output logic [INT_LANES-1:0]        out_ctl
);

   localparam int INT_W = INT_LANES * LANE_W;

   logic [INT_W-1:0]     hold_d;
   logic [INT_LANES-1:0] hold_c;
   logic [1:0]           left;
   logic [1:0]           idx;

   logic                 take_new;
   logic                 cont;
   logic [INT_W-1:0]     src_d;
   logic [INT_LANES-1:0] src_c;
   logic [1:0]           idx_use;
   logic [2:0]           shift_lanes;
   logic [INT_W-1:0]     shifted_d;
   logic [INT_LANES-1:0] shifted_c;
   logic [INT_W-1:0]     slice_d;
   logic [INT_LANES-1:0] slice_c;
   logic [1:0]           last_idx;

   always_comb begin
      take_new    = en && in_valid;
      cont        = en && (left != 2'd0);
      src_d       = take_new ? in_data : hold_d;
      src_c       = take_new ? in_ctl  : hold_c;
      idx_use     = take_new ? 2'd0    : idx;
      shift_lanes = half ? {idx_use, 1'b0} : {1'b0, idx_use};
      shifted_d   = src_d >> (int'(shift_lanes) * LANE_W);
      shifted_c   = src_c >> shift_lanes;
      last_idx    = half ? 2'd1 : 2'd3;
   end

   // Keep lane 0 always, lane 1 only in two-lane mode, zero the rest
   for (genvar g = 0; g < INT_LANES; g++) begin : g_lane
      if (g == 0) begin : g_first
         assign slice_d[g*LANE_W +: LANE_W] = shifted_d[g*LANE_W +: LANE_W];
         assign slice_c[g]                  = shifted_c[g];
      end else if (g == 1) begin : g_second
         assign slice_d[g*LANE_W +: LANE_W] = half ? shifted_d[g*LANE_W +: LANE_W] : '0;
         assign slice_c[g]                  = half & shifted_c[g];
      end else begin : g_zero
         assign slice_d[g*LANE_W +: LANE_W] = '0;
         assign slice_c[g]                  = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst || flush) begin
         hold_d    <= '0;
         hold_c    <= '0;
         left      <= 2'd0;
         idx       <= 2'd0;
         out_valid <= 1'b0;
         out_data  <= '0;
         out_ctl   <= '0;
      end else if (take_new) begin
         hold_d    <= in_data;
         hold_c    <= in_ctl;
         left      <= last_idx;
         idx       <= 2'd1;
         out_valid <= 1'b1;
         out_data  <= slice_d;
         out_ctl   <= slice_c;
      end else if (cont) begin
         left      <= left - 2'd1;
         idx       <= idx + 2'd1;
         out_valid <= 1'b1;
         out_data  <= slice_d;
         out_ctl   <= slice_c;
      end else begin
         out_valid <= 1'b0;
      end
   end

endmodule

// File: rtl/rfwa_pair.sv
module rfwa_pair
   import rfwa_pkg::*;
#(
   parameter int LANE_W = 8
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        flush,
   input  logic                        en,
   input  logic                        in_valid,
   input  logic [INT_LANES*LANE_W-1:0] in_data,
   input  logic [INT_LANES-1:0]        in_ctl,
   output logic                        out_valid,
   output logic [USR_LANES*LANE_W-1:0] out_data,
   output logic [USR_LANES-1:0]        out_ctl
);

   localparam int INT_W = INT_LANES * LANE_W;

   logic                 phase;
   logic [INT_W-1:0]     lo_d;
   logic [INT_LANES-1:0] lo_c;

   always_ff @(posedge clk) begin
      if (rst || flush) begin
         phase     <= 1'b0;
         lo_d      <= '0;
         lo_c      <= '0;
         out_valid <= 1'b0;
         out_data  <= '0;
         out_ctl   <= '0;
      end else if (en && in_valid && !phase) begin
         phase     <= 1'b1;
         lo_d      <= in_data;
         lo_c      <= in_ctl;
         out_valid <= 1'b0;
      end else if (en && in_valid) begin
         phase     <= 1'b0;
         out_valid <= 1'b1;
         out_data  <= {in_data, lo_d};
         out_ctl   <= {in_ctl, lo_c};
      end else begin
         out_valid <= 1'b0;
      end
   end

endmodule

// File: rtl/rx_fabric_width_adapter.sv
module rx_fabric_width_adapter
   import rfwa_pkg::*;
#(
   parameter int LANE_W = 8
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic [1:0]                  width_sel,
   input  logic                        int_valid,
   input  logic [INT_LANES*LANE_W-1:0] int_data,
   input  logic [INT_LANES-1:0]        int_ctl,
   output logic                        usr_valid,
   output logic [USR_LANES*LANE_W-1:0] usr_data,
   output logic [USR_LANES-1:0]        usr_ctl
);

   localparam int INT_W = INT_LANES * LANE_W;
   localparam int USR_W = USR_LANES * LANE_W;

   if (LANE_W < 1 || LANE_W > 16) begin : g_bad_lane
      $error("rx_fabric_width_adapter: LANE_W must be within 1..16");
   end

   rx_width_e width_q;
   logic      flush;

   rfwa_mode_track u_mode (
      .clk       (clk),
      .rst       (rst),
      .width_sel (width_sel),
      .width_q   (width_q),
      .flush     (flush)
   );

   logic                 sp_en;
   logic                 sp_half;
   logic                 sp_valid;
   logic [INT_W-1:0]     sp_data;
   logic [INT_LANES-1:0] sp_ctl;

   assign sp_en   = (width_q == W_1L) || (width_q == W_2L);
   assign sp_half = (width_q == W_2L);

   rfwa_spread #(.LANE_W(LANE_W)) u_spread (
      .clk       (clk),
      .rst       (rst),
      .flush     (flush),
      .en        (sp_en),
      .half      (sp_half),
      .in_valid  (int_valid),
      .in_data   (int_data),
      .in_ctl    (int_ctl),
      .out_valid (sp_valid),
      .out_data  (sp_data),
      .out_ctl   (sp_ctl)
   );

   logic                 pr_valid;
   logic [USR_W-1:0]     pr_data;
   logic [USR_LANES-1:0] pr_ctl;

   rfwa_pair #(.LANE_W(LANE_W)) u_pair (
      .clk       (clk),
      .rst       (rst),
      .flush     (flush),
      .en        (width_q == W_8L),
      .in_valid  (int_valid),
      .in_data   (int_data),
      .in_ctl    (int_ctl),
      .out_valid (pr_valid),
      .out_data  (pr_data),
      .out_ctl   (pr_ctl)
   );

   // Four-lane mode: one register stage of straight passthrough
   logic                 ps_valid;
   logic [INT_W-1:0]     ps_data;
   logic [INT_LANES-1:0] ps_ctl;

   always_ff @(posedge clk) begin
      if (rst || flush) begin
         ps_valid <= 1'b0;
         ps_data  <= '0;
         ps_ctl   <= '0;
      end else if (width_q == W_4L && int_valid) begin
         ps_valid <= 1'b1;
         ps_data  <= int_data;
         ps_ctl   <= int_ctl;
      end else begin
         ps_valid <= 1'b0;
      end
   end

   always_comb begin
      unique case (width_q)
         W_1L, W_2L: begin
            usr_valid = sp_valid;
            usr_data  = {{INT_W{1'b0}}, sp_data};
            usr_ctl   = {{INT_LANES{1'b0}}, sp_ctl};
         end
         W_4L: begin
            usr_valid = ps_valid;
            usr_data  = {{INT_W{1'b0}}, ps_data};
            usr_ctl   = {{INT_LANES{1'b0}}, ps_ctl};
         end
         default: begin
            usr_valid = pr_valid;
            usr_data  = pr_data;
            usr_ctl   = pr_ctl;
         end
      endcase
   end

endmodule

// File: rtl/rfwa_checker.sv
module rfwa_checker
   import rfwa_pkg::*;
#(
   parameter int LANE_W = 8
) (
   input logic                        clk,
   input logic                        rst,
   input logic [1:0]                  width_sel,
   input logic [1:0]                  width_q,
   input logic                        int_valid,
   input logic [INT_LANES*LANE_W-1:0] int_data,
   input logic [INT_LANES-1:0]        int_ctl,
   input logic                        usr_valid,
   input logic [USR_LANES*LANE_W-1:0] usr_data,
   input logic [USR_LANES-1:0]        usr_ctl
);

   localparam int INT_W = INT_LANES * LANE_W;
   localparam int USR_W = USR_LANES * LANE_W;

   AST_SWITCH_QUIET: assert property (@(posedge clk) disable iff (rst)
      (width_sel != width_q) |=> !usr_valid); // R10

   AST_LANE0_FIRST: assert property (@(posedge clk) disable iff (rst)
      (width_q == 2'b00 && width_sel == width_q && int_valid)
      |=> (usr_valid && usr_data[LANE_W-1:0] == $past(int_data[LANE_W-1:0])
           && usr_ctl[0] == $past(int_ctl[0]))); // R3

   AST_HALF_FIRST: assert property (@(posedge clk) disable iff (rst)
      (width_q == 2'b01 && width_sel == width_q && int_valid)
      |=> (usr_valid && usr_data[2*LANE_W-1:0] == $past(int_data[2*LANE_W-1:0]))); // R4

   AST_WORD_PASS: assert property (@(posedge clk) disable iff (rst)
      (width_q == 2'b10 && width_sel == width_q && int_valid)
      |=> (usr_valid && usr_data[INT_W-1:0] == $past(int_data)
           && usr_ctl[INT_LANES-1:0] == $past(int_ctl))); // R5

   AST_PAIR_GAP: assert property (@(posedge clk) disable iff (rst)
      (width_q == 2'b11 && usr_valid) |=> !usr_valid); // R6

   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
      (usr_valid && width_q == 2'b00)
      |-> (usr_data[USR_W-1:LANE_W] == '0 && usr_ctl[USR_LANES-1:1] == '0)); // R8

endmodule

bind rx_fabric_width_adapter rfwa_checker #(.LANE_W(LANE_W)) u_rfwa_chk (
   .clk       (clk),
   .rst       (rst),
   .width_sel (width_sel),
   .width_q   (width_q),
   .int_valid (int_valid),
   .int_data  (int_data),
   .int_ctl   (int_ctl),
   .usr_valid (usr_valid),
   .usr_data  (usr_data),
   .usr_ctl   (usr_ctl)
);

// File: tb/rx_fabric_width_adapter_bench.sv
module rx_fabric_width_adapter_bench;

   logic        clk = 1'b0;
   logic        rst;
   logic [1:0]  width_sel;
   logic        int_valid;
   logic [31:0] int_data;
   logic [3:0]  int_ctl;
   logic        usr_valid;
   logic [63:0] usr_data;
   logic [7:0]  usr_ctl;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   typedef struct {
      logic [63:0] d;
      logic [7:0]  c;
      string       req;
   } exp_t;

   exp_t sb[$];

   always #10 clk = ~clk;

   rx_fabric_width_adapter u_rx_fabric_width_adapter (
      .clk       (clk),
      .rst       (rst),
      .width_sel (width_sel),
      .int_valid (int_valid),
      .int_data  (int_data),
      .int_ctl   (int_ctl),
      .usr_valid (usr_valid),
      .usr_data  (usr_data),
      .usr_ctl   (usr_ctl)
   );

   task automatic check(input bit ok, input string req, input logic [71:0] act,
                        input logic [71:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic push(input logic [63:0] d, input logic [7:0] c, input string req);
      exp_t e;
      e.d = d; e.c = c; e.req = req;
      sb.push_back(e);
   endtask

   // Expected slices for a narrow mode: lanes per user word = n
   task automatic push_narrow(input logic [31:0] d, input logic [3:0] c, input int n,
                              input int count, input string req);
      for (int i = 0; i < count; i++) begin
         logic [63:0] md = (64'd1 << (8*n)) - 64'd1;
         logic [7:0]  mc = (8'd1 << n) - 8'd1;
         push(({32'd0, d} >> (8*n*i)) & md, ({4'd0, c} >> (n*i)) & mc, req);
      end
   endtask

   task automatic drive_word(input logic [31:0] d, input logic [3:0] c);
      int_valid = 1'b1;
      int_data  = d;
      int_ctl   = c;
      @(negedge clk);
      int_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_width(input logic [1:0] w);
      width_sel = w;
      @(negedge clk);
      check(!usr_valid, "R10 quiet after width change", {71'd0, usr_valid}, 72'd0);
   endtask

   // Monitor: every user word is compared against the scoreboard head
   always @(negedge clk) begin
      if (!rst && usr_valid) begin
         if (sb.size() == 0) begin
            check(1'b0, "R10 unexpected user word", {usr_ctl, usr_data}, 72'd0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(usr_data == e.d && usr_ctl == e.c, e.req,
                  {usr_ctl, usr_data}, {e.c, e.d});
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; width_sel = 2'b10; int_valid = 1'b0; int_data = '0; int_ctl = '0;
      repeat (3) @(negedge clk);
      check(!usr_valid && usr_data == '0 && usr_ctl == '0, "R1 reset state",
            {usr_ctl, usr_data}, 72'd0);
      rst = 1'b0;
      @(negedge clk);
      check(!usr_valid && usr_data == '0, "R1 idle after reset", {usr_ctl, usr_data}, 72'd0);

      // R5 / R2: four-lane passthrough, back to back
      push(64'h0000_0000_1122_3344, 8'h05, "R5 pass word 0");
      drive_word(32'h1122_3344, 4'h5);
      push(64'h0000_0000_A5A5_0F0F, 8'h0A, "R5 pass word 1");
      drive_word(32'hA5A5_0F0F, 4'hA);
      push(64'h0000_0000_DEAD_BEEF, 8'h01, "R7 pass ctl");
      drive_word(32'hDEAD_BEEF, 4'h1);
      idle(3);

      // R3: one-lane distribution, lane 0 first, R8 upper zero
      set_width(2'b00);
      push_narrow(32'h4433_2211, 4'h6, 1, 4, "R3 byte slice");
      drive_word(32'h4433_2211, 4'h6);
      idle(3);
      push_narrow(32'hF0E1_D2C3, 4'h9, 1, 4, "R7 byte ctl");
      drive_word(32'hF0E1_D2C3, 4'h9);
      idle(3);
      push_narrow(32'hFFFF_FFFF, 4'hF, 1, 4, "R8 byte upper zero");
      drive_word(32'hFFFF_FFFF, 4'hF);
      idle(5);

      // R4: two-lane distribution
      set_width(2'b01);
      push_narrow(32'h8765_4321, 4'h2, 2, 2, "R4 half slice");
      drive_word(32'h8765_4321, 4'h2);
      idle(1);
      push_narrow(32'hFFFF_FFFF, 4'hC, 2, 2, "R8 half upper zero");
      drive_word(32'hFFFF_FFFF, 4'hC);
      idle(4);

      // R6: eight-lane pairing, earlier word low
      set_width(2'b11);
      drive_word(32'h0101_0202, 4'h3);
      push(64'h0303_0404_0101_0202, 8'hC3, "R6 pair low first");
      drive_word(32'h0303_0404, 4'hC);
      drive_word(32'hCAFE_0001, 4'h0);
      idle(2);
      push(64'h0000_FACE_CAFE_0001, 8'h80, "R7 pair ctl with gap");
      drive_word(32'h0000_FACE, 4'h8);
      idle(3);

      // R9: restart before the previous word is fully handed out
      set_width(2'b00);
      push_narrow(32'hAA99_8877, 4'h1, 1, 2, "R9 old word head");
      push_narrow(32'h5566_7788, 4'h8, 1, 4, "R9 new word takes over");
      drive_word(32'hAA99_8877, 4'h1);
      idle(1);
      drive_word(32'h5566_7788, 4'h8);
      idle(5);

      // R10: width change in the middle of a one-lane burst
      push_narrow(32'h1357_9BDF, 4'hF, 1, 1, "R10 burst head");
      drive_word(32'h1357_9BDF, 4'hF);
      set_width(2'b01);
      idle(4);

      // R10: width change with a pair half held, int_valid on the switch cycle
      set_width(2'b11);
      drive_word(32'hBAD0_BAD0, 4'hF);
      width_sel = 2'b10;
      drive_word(32'hBAD1_BAD1, 4'hF);
      check(!usr_valid, "R10 switch cycle word dropped", {71'd0, usr_valid}, 72'd0);
      set_width(2'b11);
      drive_word(32'h2222_1111, 4'h1);
      push(64'h4444_3333_2222_1111, 8'h21, "R10 pair starts clean");
      drive_word(32'h4444_3333, 4'h2);
      idle(6);

      check(sb.size() == 0, "R10 scoreboard drained", 72'(sb.size()), 72'd0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule